// File: doc/BRIEF.md
# Dual-Channel TDM Serial Port

This block is the serial side of a two-channel voice converter. It moves 16-bit words for two logical channels over a single time-division-multiplexed link made of a bit clock, a frame marker, a serial input line and a serial output line. A frame holds 256 bit periods, split into sixteen 16-bit slots. The two channels always sit in two adjacent slots. A 2-bit strap picks the pair. Outside those two slots the output line is released: its enable is low, so other devices can share the wire.

The port can generate the link timing itself (master) or follow timing supplied by another device (slave). In master mode the bit clock is a divided copy of the system clock and the frame marker pulses once every 256 bit periods. In slave mode the bit clock and frame marker come in as inputs that are synchronous to the system clock. All of these are sampled in the system clock domain. On the parallel side, two transmit words are taken in at each frame start. Two receive words are handed out, each with a one-cycle strobe.

Top module: `duo_tdm_port`

## Requirements
- R1: With `master_en` high, `bclk_out` is a square wave whose period is 2*HALF_DIV system clocks. With `master_en` low, `bclk_out` and `fsync_out` stay low.
- R2: In master mode `fsync_out` goes high once every 256 rising edges of `bclk_out` and is seen high at exactly one of them. It changes only together with a falling edge of `bclk_out`.
- R3: A frame starts when the frame marker is high at a rising bit-clock edge; that bit period is bit 0 of slot 0. In slave mode the marker and bit clock are `fsync_in` and `bclk_in`. Until the first frame start, `sdout_oe` stays low and no receive strobe is raised.
- R4: Output bits change after rising bit-clock edges, MSB first. Slot s covers frame bits 16*s to 16*s+15. `tx_word_a` goes out in slot 2*N and `tx_word_b` in slot 2*N+1, where N is `slot_sel`, read as an unsigned number with bit 1 as its MSB.
- R5: `sdout_oe` is high during the two assigned slots and low in every other bit period of the frame.
- R6: `sdin` is captured at falling bit-clock edges, MSB first. Slot 2*N fills `rx_word_a` and slot 2*N+1 fills `rx_word_b`. Bits in other slots never reach either word.
- R7: After the last bit of each assigned receive slot, the matching `rx_valid` is high for exactly one system clock, once per slot. The word stays stable until that channel's next slot completes.
- R8: The transmit words are taken in at frame start. A change to `tx_word_a` or `tx_word_b` during a frame only shows in the next frame.
- R9: A frame marker seen in the middle of a frame restarts the bit count at bit 0 of slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1: generate bit clock and frame marker; 0: follow the inputs |
| slot_sel | input | 2 | Strap N; channels use slots 2N and 2N+1 |
| bclk_in | input | 1 | Bit clock from the link in slave mode |
| fsync_in | input | 1 | Frame marker from the link in slave mode |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| fsync_out | output | 1 | Generated frame marker (master mode) |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial transmit data |
| sdout_oe | output | 1 | Drive enable for the serial output pad |
| tx_word_a | input | 16 | Transmit word, channel A |
| tx_word_b | input | 16 | Transmit word, channel B |
| rx_word_a | output | 16 | Received word, channel A |
| rx_valid_a | output | 1 | One-cycle strobe for a new channel A word |
| rx_word_b | output | 16 | Received word, channel B |
| rx_valid_b | output | 1 | One-cycle strobe for a new channel B word |

## Verification
A wrong bit position shows up within one bit period as `sdout_oe` asserted or released at the wrong frame bit, and the bench checks this for every strap value. A receive count that has slipped shows up at the end of the affected slot as a wrong word or a missing or extra strobe. A master divider or frame counter that is off shows up within one bit period as a wrong clock period, and within one frame as a frame marker at the wrong edge count. Transmit words taken in at the wrong moment appear within one frame as mixed old and new data.

// File: rtl/duo_tdm_pkg.sv
package duo_tdm_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } owner_e;

  // Which channel owns frame bit 'pos' for strap value 'sel'.
  function automatic owner_e slot_owner(input int unsigned pos,
                                        input int unsigned sel,
                                        input int unsigned word_w);
    int unsigned slot;
    slot = pos / word_w;
    if (slot == 2 * sel)          return OWN_A;
    else if (slot == 2 * sel + 1) return OWN_B;
    else                          return OWN_NONE;
  endfunction

  // Offset of frame bit 'pos' inside its slot (0 = first bit, the MSB).
  function automatic int unsigned bit_in_slot(input int unsigned pos,
                                              input int unsigned word_w);
    return pos % word_w;
  endfunction

endpackage

// File: rtl/duo_tdm_clkgen.sv
module duo_tdm_clkgen #(
  parameter int HALF_DIV   = 2,
  parameter int FRAME_BITS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic bclk_o,
  output logic fsync_o
);
  localparam int DIV_W = $clog2(HALF_DIV) + 1;
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] bitc_q;
  logic             half_done;

  assign half_done = (div_q == DIV_W'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      bitc_q  <= LAST_BIT;
      bclk_o  <= 1'b0;
      fsync_o <= 1'b0;
    end else if (!enable) begin
      div_q   <= '0;
      bitc_q  <= LAST_BIT;
      bclk_o  <= 1'b0;
      fsync_o <= 1'b0;
    end else if (half_done) begin
      div_q  <= '0;
      bclk_o <= ~bclk_o;
      if (bclk_o) begin
        // falling edge: advance bit period, frame marker follows
        bitc_q  <= (bitc_q == LAST_BIT) ? '0 : bitc_q + 1'b1;
        fsync_o <= (bitc_q == LAST_BIT);
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/duo_tdm_edges.sv
module duo_tdm_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic master_en,
  input  logic bclk_gen,
  input  logic fsync_gen,
  input  logic bclk_in,
  input  logic fsync_in,
  output logic rise_o,
  output logic fall_o,
  output logic fs_o
);
  logic bclk_s, fsync_s, lvl, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_s  <= 1'b0;
      fsync_s <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      bclk_s  <= bclk_in;
      fsync_s <= fsync_in;
      prev_q  <= lvl;
    end
  end

  assign lvl    = master_en ? bclk_gen  : bclk_s;
  assign fs_o   = master_en ? fsync_gen : fsync_s;
  assign rise_o = lvl & ~prev_q;
  assign fall_o = ~lvl & prev_q;
endmodule

// File: rtl/duo_tdm_framer.sv
module duo_tdm_framer #(
  parameter int FRAME_BITS = 256,
  localparam int POS_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fs,
  output logic             frame_hit,
  output logic [POS_W-1:0] pos_q,
  output logic [POS_W-1:0] pos_nx,
  output logic             synced_q,
  output logic             synced_nx
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  assign frame_hit = rise & fs;
  assign synced_nx = synced_q | frame_hit;

  always_comb begin
    if (frame_hit)              pos_nx = '0;
    else if (pos_q == LAST_POS) pos_nx = '0;
    else                        pos_nx = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      synced_q <= 1'b0;
    end else if (rise && synced_nx) begin
      pos_q    <= pos_nx;
      synced_q <= 1'b1;
    end
  end
endmodule

// File: rtl/duo_tdm_tx.sv
module duo_tdm_tx
  import duo_tdm_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int POS_W  = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              frame_hit,
  input  logic              synced_nx,
  input  logic [POS_W-1:0]  pos_nx,
  input  logic [SEL_W-1:0]  slot_sel,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  output logic              sdout,
  output logic              sdout_oe
);
  localparam int BIT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] held_a, held_b, cur_a, cur_b;
  owner_e            own;
  logic [BIT_W-1:0]  idx;

  assign cur_a = frame_hit ? word_a : held_a;
  assign cur_b = frame_hit ? word_b : held_b;
  assign own   = slot_owner(32'(pos_nx), 32'(slot_sel), WORD_W);
  assign idx   = BIT_W'(WORD_W - 1 - int'(bit_in_slot(32'(pos_nx), WORD_W)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_a   <= '0;
      held_b   <= '0;
      sdout    <= 1'b0;
      sdout_oe <= 1'b0;
    end else if (rise) begin
      if (frame_hit) begin
        held_a <= word_a;
        held_b <= word_b;
      end
      if (synced_nx && own == OWN_A) begin
        sdout    <= cur_a[idx];
        sdout_oe <= 1'b1;
      end else if (synced_nx && own == OWN_B) begin
        sdout    <= cur_b[idx];
        sdout_oe <= 1'b1;
      end else begin
        sdout    <= 1'b0;
        sdout_oe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/duo_tdm_rx.sv
module duo_tdm_rx
  import duo_tdm_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int POS_W  = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              synced_q,
  input  logic [POS_W-1:0]  pos_q,
  input  logic [SEL_W-1:0]  slot_sel,
  input  logic              sdin,
  output logic [WORD_W-1:0] word_a,
  output logic              valid_a,
  output logic [WORD_W-1:0] word_b,
  output logic              valid_b
);
  logic [WORD_W-1:0] shift_q, assembled;
  owner_e            own;
  int unsigned       offs;
  logic              first_bit, last_bit;

  assign own       = slot_owner(32'(pos_q), 32'(slot_sel), WORD_W);
  assign offs      = bit_in_slot(32'(pos_q), WORD_W);
  assign first_bit = (offs == 0);
  assign last_bit  = (offs == WORD_W - 1);
  assign assembled = first_bit ? {{(WORD_W-1){1'b0}}, sdin}
                               : {shift_q[WORD_W-2:0], sdin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      word_a  <= '0;
      word_b  <= '0;
      valid_a <= 1'b0;
      valid_b <= 1'b0;
    end else begin
      valid_a <= 1'b0;
      valid_b <= 1'b0;
      if (fall && synced_q && own != OWN_NONE) begin
        shift_q <= assembled;
        if (last_bit && own == OWN_A) begin
          word_a  <= assembled;
          valid_a <= 1'b1;
        end
        if (last_bit && own == OWN_B) begin
          word_b  <= assembled;
          valid_b <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/duo_tdm_port.sv
module duo_tdm_port #(
  parameter int WORD_W   = 16,
  parameter int SLOTS    = 16,
  parameter int SEL_W    = 2,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic [SEL_W-1:0]  slot_sel,
  input  logic              bclk_in,
  input  logic              fsync_in,
  output logic              bclk_out,
  output logic              fsync_out,
  input  logic              sdin,
  output logic              sdout,
  output logic              sdout_oe,
  input  logic [WORD_W-1:0] tx_word_a,
  input  logic [WORD_W-1:0] tx_word_b,
  output logic [WORD_W-1:0] rx_word_a,
  output logic              rx_valid_a,
  output logic [WORD_W-1:0] rx_word_b,
  output logic              rx_valid_b
);
  localparam int FRAME_BITS = WORD_W * SLOTS;
  localparam int POS_W      = $clog2(FRAME_BITS);

  // named internal events, visible to the bound checker
  logic             rise_evt, fall_evt, fs_lvl, frame_hit;
  logic             synced, synced_nx;
  logic [POS_W-1:0] pos_q, pos_nx;

  duo_tdm_clkgen #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .enable(master_en),
    .bclk_o(bclk_out), .fsync_o(fsync_out)
  );

  duo_tdm_edges edges_i (
    .clk(clk), .rst_n(rst_n), .master_en(master_en),
    .bclk_gen(bclk_out), .fsync_gen(fsync_out),
    .bclk_in(bclk_in), .fsync_in(fsync_in),
    .rise_o(rise_evt), .fall_o(fall_evt), .fs_o(fs_lvl)
  );

  duo_tdm_framer #(.FRAME_BITS(FRAME_BITS)) framer_i (
    .clk(clk), .rst_n(rst_n), .rise(rise_evt), .fs(fs_lvl),
    .frame_hit(frame_hit), .pos_q(pos_q), .pos_nx(pos_nx),
    .synced_q(synced), .synced_nx(synced_nx)
  );

  duo_tdm_tx #(.WORD_W(WORD_W), .POS_W(POS_W), .SEL_W(SEL_W)) tx_i (
    .clk(clk), .rst_n(rst_n), .rise(rise_evt), .frame_hit(frame_hit),
    .synced_nx(synced_nx), .pos_nx(pos_nx), .slot_sel(slot_sel),
    .word_a(tx_word_a), .word_b(tx_word_b),
    .sdout(sdout), .sdout_oe(sdout_oe)
  );

  duo_tdm_rx #(.WORD_W(WORD_W), .POS_W(POS_W), .SEL_W(SEL_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .fall(fall_evt), .synced_q(synced),
    .pos_q(pos_q), .slot_sel(slot_sel), .sdin(sdin),
    .word_a(rx_word_a), .valid_a(rx_valid_a),
    .word_b(rx_word_b), .valid_b(rx_valid_b)
  );
endmodule

// File: rtl/duo_tdm_port_chk.sv
module duo_tdm_port_chk #(
  parameter int POS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             master_en,
  input logic             bclk_out,
  input logic             fsync_out,
  input logic             sdout,
  input logic             sdout_oe,
  input logic             rx_valid_a,
  input logic             rx_valid_b,
  input logic             rise_evt,
  input logic             fall_evt,
  input logic             frame_hit,
  input logic             synced,
  input logic [POS_W-1:0] pos_q
);
  assert_slave_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> (!bclk_out && !fsync_out));

  assert_fsync_at_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_out) |-> !bclk_out);

  assert_no_drive_unsynced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sdout_oe |-> synced);

  assert_launch_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_evt |=> ($stable(sdout) && $stable(sdout_oe)));

  assert_capture_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_a || rx_valid_b) |-> $past(fall_evt));

  assert_strobe_single_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_a |=> !rx_valid_a);

  assert_strobe_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid_a && rx_valid_b));

  assert_resync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_hit |=> (pos_q == '0));
endmodule

bind duo_tdm_port duo_tdm_port_chk #(.POS_W(POS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .master_en(master_en),
  .bclk_out(bclk_out), .fsync_out(fsync_out),
  .sdout(sdout), .sdout_oe(sdout_oe),
  .rx_valid_a(rx_valid_a), .rx_valid_b(rx_valid_b),
  .rise_evt(rise_evt), .fall_evt(fall_evt), .frame_hit(frame_hit),
  .synced(synced), .pos_q(pos_q)
);

// File: tb/duo_tdm_port_tb_top.sv
`timescale 1ns/1ps
module duo_tdm_port_tb_top;
  localparam int HD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master_en = 1'b0;
  logic [1:0]  slot_sel = 2'd0;
  logic        bclk_in = 1'b0, fsync_in = 1'b0, sdin = 1'b0;
  logic        bclk_out, fsync_out, sdout, sdout_oe;
  logic [15:0] tx_word_a = '0, tx_word_b = '0;
  logic [15:0] rx_word_a, rx_word_b;
  logic        rx_valid_a, rx_valid_b;

  int n_chk = 0, n_bad = 0;
  int cnt_a = 0, cnt_b = 0;
  logic [15:0] seen_a, seen_b;
  bit done = 0;

  always #2 clk = ~clk;

  duo_tdm_port #(.HALF_DIV(HD)) dut_i (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .slot_sel(slot_sel),
    .bclk_in(bclk_in), .fsync_in(fsync_in), .bclk_out(bclk_out),
    .fsync_out(fsync_out), .sdin(sdin), .sdout(sdout), .sdout_oe(sdout_oe),
    .tx_word_a(tx_word_a), .tx_word_b(tx_word_b),
    .rx_word_a(rx_word_a), .rx_valid_a(rx_valid_a),
    .rx_word_b(rx_word_b), .rx_valid_b(rx_valid_b)
  );

  always @(negedge clk) begin
    if (rx_valid_a) begin cnt_a++; seen_a = rx_word_a; end
    if (rx_valid_b) begin cnt_b++; seen_b = rx_word_b; end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // 0 none, 1 channel A, 2 channel B
  function automatic int who(input int k, input logic [1:0] sel);
    logic [3:0] s;
    s = 4'(k >> 4);
    if (s == {1'b0, sel, 1'b0}) return 1;
    if (s == {1'b0, sel, 1'b1}) return 2;
    return 0;
  endfunction

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One slave-mode frame of 'len' bits starting with the marker.
  task automatic run_frame(input logic [1:0] sel, input int len,
                           input logic [15:0] ea, input logic [15:0] eb,
                           input logic [15:0] ra, input logic [15:0] rb,
                           input int chg_at, input logic [15:0] na,
                           input logic [15:0] nb, input string txreq);
    int bad_oe, bad_dat;
    bad_oe = 0; bad_dat = 0;
    slot_sel = sel;
    cnt_a = 0; cnt_b = 0;
    for (int k = 0; k < len; k++) begin
      int w, b;
      logic expd;
      w = who(k, sel);
      b = 15 - (k & 15);
      if (k == chg_at) begin tx_word_a = na; tx_word_b = nb; end
      bclk_in  = 1'b1;
      fsync_in = (k == 0);
      sdin = (w == 1) ? ra[b] : (w == 2) ? rb[b] : ((k & 1) ^ ((k >> 3) & 1)) == 1;
      wait_neg(3);
      expd = (w == 1) ? ea[b] : eb[b];
      if (sdout_oe !== (w != 0)) begin
        bad_oe++;
        if (bad_oe == 1) check("R5", $sformatf("oe at bit %0d", k), 32'(sdout_oe), 32'(w != 0));
      end else if (w != 0 && sdout !== expd) begin
        bad_dat++;
        if (bad_dat == 1) check(txreq, $sformatf("sdout at bit %0d", k), 32'(sdout), 32'(expd));
      end
      wait_neg(1);
      bclk_in = 1'b0;
      wait_neg(4);
    end
    if (bad_oe == 0) check("R5", "oe window per frame", 0, 0);
    if (bad_dat == 0) check(txreq, "tx bits per frame", 0, 0);
  endtask

  task automatic check_rx(input logic [15:0] ra, input logic [15:0] rb, input string req);
    check("R7", "strobe count a", 32'(cnt_a), 1);
    check("R7", "strobe count b", 32'(cnt_b), 1);
    check(req, "rx word a", 32'(seen_a), 32'(ra));
    check(req, "rx word b", 32'(seen_b), 32'(rb));
  endtask

  task automatic t_reset;
    check("R1", "bclk_out after reset", 32'(bclk_out), 0);
    check("R1", "fsync_out after reset", 32'(fsync_out), 0);
    check("R3", "oe after reset", 32'(sdout_oe), 0);
    cnt_a = 0; cnt_b = 0;
    slot_sel = 2'd0;
    tx_word_a = 16'hFFFF;
    for (int k = 0; k < 40; k++) begin
      bclk_in = 1'b1; sdin = 1'b1; wait_neg(4);
      if (sdout_oe !== 1'b0) check("R3", "oe before first frame", 32'(sdout_oe), 0);
      bclk_in = 1'b0; wait_neg(4);
    end
    check("R3", "no drive before first frame", 32'(sdout_oe), 0);
    check("R3", "no strobes before first frame", 32'(cnt_a + cnt_b), 0);
  endtask

  task automatic t_sweep;
    for (int s = 0; s < 4; s++) begin
      logic [15:0] a, b, ra, rb;
      a  = 16'hA5C3 ^ 16'(s * 16'h1111);
      b  = 16'h5A3C + 16'(s * 16'h0707);
      ra = 16'h8001 ^ 16'(s << 5);
      rb = 16'h7E18 ^ 16'(s * 16'h0321);
      tx_word_a = a; tx_word_b = b;
      run_frame(2'(s), 256, a, b, ra, rb, -1, a, b, "R4");
      check_rx(ra, rb, "R6");
    end
  endtask

  task automatic t_mid_update;
    tx_word_a = 16'h1234; tx_word_b = 16'hFEDC;
    run_frame(2'd2, 256, 16'h1234, 16'hFEDC, 16'h0F0F, 16'hF00F, 20, 16'hBEEF, 16'h0BAD, "R8");
    run_frame(2'd2, 256, 16'hBEEF, 16'h0BAD, 16'h3C3C, 16'hC33C, -1, 16'hBEEF, 16'h0BAD, "R8");
    check_rx(16'h3C3C, 16'hC33C, "R6");
  endtask

  task automatic t_resync;
    tx_word_a = 16'h2468; tx_word_b = 16'h1357;
    run_frame(2'd1, 100, 16'h2468, 16'h1357, 16'h4444, 16'h2222, -1, 16'h2468, 16'h1357, "R9");
    run_frame(2'd1, 256, 16'h2468, 16'h1357, 16'h9669, 16'h6996, -1, 16'h2468, 16'h1357, "R9");
    check_rx(16'h9669, 16'h6996, "R9");
  endtask

  task automatic t_master;
    int k, frames, flen, fhigh, bad_oe;
    realtime t0, t1;
    k = -1; frames = 0; flen = 0; fhigh = 0; bad_oe = 0;
    slot_sel = 2'd3;
    master_en = 1'b1;
    @(posedge bclk_out); t0 = $realtime;
    @(posedge bclk_out); t1 = $realtime;
    check("R1", "bclk period in clocks", 32'(int'((t1 - t0) / 4.0)), 32'(2 * HD));
    while (frames < 3) begin
      @(posedge bclk_out); #1;
      if (fsync_out) begin
        if (k >= 0) begin
          frames++;
          if (frames >= 2) begin
            check("R2", "bits per master frame", 32'(flen), 256);
            check("R2", "marker edges per frame", 32'(fhigh), 1);
          end
        end
        k = 0; flen = 1; fhigh = 1;
      end else if (k >= 0) begin
        k = (k + 1) % 256; flen++;
      end
      @(negedge bclk_out); #1;
      if (k >= 0 && sdout_oe !== (who(k, 2'd3) != 0)) begin
        bad_oe++;
        if (bad_oe == 1) check("R5", $sformatf("master oe bit %0d", k), 32'(sdout_oe), 32'(who(k, 2'd3) != 0));
      end
    end
    if (bad_oe == 0) check("R5", "master oe windows", 0, 0);
    master_en = 1'b0;
    wait_neg(3);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bclk_out !== 1'b0) begin check("R1", "bclk low in slave", 32'(bclk_out), 0); break; end
    end
    check("R1", "outputs quiet in slave", 32'({bclk_out, fsync_out}), 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    wait_neg(5);
    rst_n = 1'b1;
    wait_neg(2);
    t_reset();
    t_sweep();
    t_mid_update();
    t_resync();
    t_master();
    finish_run();
  end
endmodule